// File: doc/BRIEF.md
# ATA Host Register File and Access Router

This block sits between a 32-bit register bus and the rest of a parallel ATA host controller. Each bus access is sorted by one address bit. Accesses with that bit clear go to the host's own registers. These are a control word, a status word, a compatible PIO timing word, two fast PIO timing words (one per device) and two DMA timing words. Accesses with that bit set go to the attached drive. They are forwarded on a downstream request interface together with the low seven address bits, the selected device and the timing word that the PIO cycle generator should use.

The downstream side completes forwarded accesses, and its acknowledge and read data pass straight back to the bus. Internal accesses, and drive accesses that the enable bit blocks, complete locally after a fixed two-cycle latency. The core version parameter decides which internal registers exist. The block remembers the selected device by watching host writes to the drive's device/head register.

Top module: `ata_host_regs`

## Requirements
- R1: After reset the control word reads 0x00000001, so `drv_rst_o` is 1. The compatible and fast PIO timing words read 0x17021C06, with end-of-cycle in 31:24, T4 in 23:16, T2 in 15:8 and T1 in 7:0. The DMA timing words read 0x15001504, with end-of-cycle in 31:24, Td in 15:8 and Tm in 7:0. The interrupt bit reads 0.
- R2: The status word (offset 0x04) returns the core version in bits 31:28 and the revision in bits 27:24. Writes never change these fields.
- R3: Status bit 0 is the interrupt flag, and `irq_o` shows it. It is set by `irq_i` being high at a clock edge. A status write replaces it with (old AND written bit 0). When `irq_i` is high in the same cycle, the set wins.
- R4: `drv_rst_o` equals bit 0 of the control word. It changes only on a control write (offset 0x00), taking the written bit 0.
- R5: When control bit 7 (enable) is 0, a drive access (address bit 7 = 1) raises no `drv_req_o`. Instead it completes locally in 2 cycles: a read returns 0 and a write is dropped, including its device-select side effect.
- R6: Address bit 7 = 0 selects internal registers, and these never raise `drv_req_o`. With enable set, a drive access raises `drv_req_o` in the request cycle with `drv_addr_o` = address bits 6:0, and `drv_we_o` and `drv_wdata_o` copied from the bus.
- R7: A forwarded access to drive offset 0x00 (data) uses fast timing word 1 when the selected device is 1, and fast timing word 0 otherwise. All other drive offsets use the compatible timing word. The selected device is bit 4 of the last forwarded write to drive offset 0x18 (reset 0), and `drv_dev_o` shows it.
- R8: An internal or blocked access requested in cycle n raises `ack_o` for one cycle in cycle n+2.
- R9: Internal offsets are word-indexed by address bits 4:2 when bits 6:5 are 0: 0x00 control, 0x04 status, 0x08 compatible timing, 0x0C/0x10 fast timing 0/1, 0x14/0x18 DMA timing 0/1, 0x1C receive buffer (read-only, value from `rxbuf_i`). Other offsets read 0, and writes to them or to 0x1C change nothing.
- R10: With version 1 only control, status and compatible timing are readable, and every drive access uses the compatible timing word. Version 2 adds the fast timing words. Version 3 adds the DMA timing words and the receive buffer.
- R11: A forwarded access completes when `drv_ack_i` is high. `ack_o` follows it in the same cycle, and `rdata_o` carries `drv_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address; bit 7 selects drive space |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access complete |
| rdata_o | output | 32 | Read data, valid with ack_o |
| rxbuf_i | input | 32 | Receive buffer word for offset 0x1C |
| irq_i | input | 1 | Drive interrupt request |
| irq_o | output | 1 | Interrupt flag |
| drv_rst_o | output | 1 | Drive hardware reset |
| drv_req_o | output | 1 | Forwarded drive access |
| drv_we_o | output | 1 | Forwarded write flag |
| drv_addr_o | output | 7 | Drive register offset |
| drv_wdata_o | output | 32 | Forwarded write data |
| drv_dev_o | output | 1 | Selected device |
| drv_timing_o | output | 32 | Timing word for this access |
| drv_ack_i | input | 1 | Downstream completion |
| drv_rdata_i | input | 32 | Downstream read data |

## Verification
The hardest case to reach is the fast timing word for device 1. To get there, the enable bit must first be set by a control write, and then a forwarded write to drive offset 0x18 must set the device bit. Only then does a data-register access pick fast word 1. The stimulus runs that sequence, and then clears the enable bit and writes the device register again, to show through `drv_dev_o` and the timing word that the blocked write left the selection alone. The interrupt flag is driven by `irq_i` high at the same time as a clearing status write, which exercises the set-over-clear priority.

// File: rtl/ahr_pkg.sv
package ahr_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_PIO   = 3'd2,
    SEL_FAST0 = 3'd3,
    SEL_FAST1 = 3'd4,
    SEL_DMA0  = 3'd5,
    SEL_DMA1  = 3'd6,
    SEL_BUF   = 3'd7
  } reg_sel_e;

  function automatic logic [31:0] pio_word(input logic [7:0] t1, input logic [7:0] t2,
                                           input logic [7:0] t4, input logic [7:0] teoc);
    return {teoc, t4, t2, t1};
  endfunction

  function automatic logic [31:0] dma_word(input logic [7:0] tm, input logic [7:0] td,
                                           input logic [7:0] teoc);
    return {teoc, 8'h00, td, tm};
  endfunction
endpackage

// File: rtl/ahr_regfile.sv
module ahr_regfile
  import ahr_pkg::*;
#(
  parameter int unsigned    CORE_VER = 3,
  parameter int unsigned    DW       = 32,
  parameter logic [DW-1:0]  CTRL_RST = 'h1,
  parameter logic [DW-1:0]  PIO_RST  = '0,
  parameter logic [DW-1:0]  DMA_RST  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  reg_sel_e            wsel_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                irq_i,
  output logic [DW-1:0]       ctrl_o,
  output logic                ist_o,
  output logic [DW-1:0]       pio_o,
  output logic [1:0][DW-1:0]  fast_o,
  output logic [1:0][DW-1:0]  dma_o
);
  logic stat_clr;
  assign stat_clr = wr_i && (wsel_i == SEL_STAT) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
      ist_o  <= 1'b0;
      pio_o  <= PIO_RST;
    end else begin
      if (wr_i && wsel_i == SEL_CTRL) ctrl_o <= wdata_i;
      if (wr_i && wsel_i == SEL_PIO)  pio_o  <= wdata_i;
      ist_o <= irq_i | (ist_o & ~stat_clr);  // set wins over clear
    end
  end

  if (CORE_VER >= 2) begin : g_fast
    for (genvar i = 0; i < 2; i++) begin : g_dev
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fast_o[i] <= PIO_RST;
        else if (wr_i && wsel_i == ((i == 0) ? SEL_FAST0 : SEL_FAST1)) fast_o[i] <= wdata_i;
      end
    end
  end else begin : g_no_fast
    assign fast_o = '0;
  end

  if (CORE_VER >= 3) begin : g_dma
    for (genvar i = 0; i < 2; i++) begin : g_ch
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dma_o[i] <= DMA_RST;
        else if (wr_i && wsel_i == ((i == 0) ? SEL_DMA0 : SEL_DMA1)) dma_o[i] <= wdata_i;
      end
    end
  end else begin : g_no_dma
    assign dma_o = '0;
  end
endmodule

// File: rtl/ahr_route.sv
module ahr_route #(
  parameter int unsigned           CORE_VER    = 3,
  parameter int unsigned           DW          = 32,
  parameter int unsigned           DRV_AW      = 7,
  parameter logic [DRV_AW-1:0]     DATA_OFF    = 'h00,
  parameter logic [DRV_AW-1:0]     DEVHEAD_OFF = 'h18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fwd_i,
  input  logic                we_i,
  input  logic [DRV_AW-1:0]   addr_i,
  input  logic                dev_bit_i,
  input  logic [DW-1:0]       pio_i,
  input  logic [1:0][DW-1:0]  fast_i,
  output logic [DW-1:0]       timing_o,
  output logic                dev_o
);
  logic use_fast;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dev_o <= 1'b0;
    else if (fwd_i && we_i && addr_i == DEVHEAD_OFF) dev_o <= dev_bit_i;
  end

  assign use_fast = (CORE_VER >= 2) && (addr_i == DATA_OFF);
  assign timing_o = use_fast ? fast_i[dev_o] : pio_i;
endmodule

// File: rtl/ahr_resp.sv
module ahr_resp
  import ahr_pkg::*;
#(
  parameter int unsigned CORE_VER = 3,
  parameter int unsigned DW       = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_i,
  input  logic                hit_i,
  input  reg_sel_e            sel_i,
  input  logic [DW-1:0]       ctrl_i,
  input  logic [DW-1:0]       stat_i,
  input  logic [DW-1:0]       pio_i,
  input  logic [1:0][DW-1:0]  fast_i,
  input  logic [1:0][DW-1:0]  dma_i,
  input  logic [DW-1:0]       rxbuf_i,
  input  logic                drv_ack_i,
  input  logic [DW-1:0]       drv_rdata_i,
  output logic                ack_o,
  output logic [DW-1:0]       rdata_o
);
  localparam bit HAS_FAST = CORE_VER >= 2;
  localparam bit HAS_DMA  = CORE_VER >= 3;

  logic [DW-1:0] mux;
  logic          v1_q, v2_q;
  logic [DW-1:0] d1_q, d2_q;

  always_comb begin
    unique case (sel_i)
      SEL_CTRL:  mux = ctrl_i;
      SEL_STAT:  mux = stat_i;
      SEL_PIO:   mux = pio_i;
      SEL_FAST0: mux = HAS_FAST ? fast_i[0] : '0;
      SEL_FAST1: mux = HAS_FAST ? fast_i[1] : '0;
      SEL_DMA0:  mux = HAS_DMA  ? dma_i[0]  : '0;
      SEL_DMA1:  mux = HAS_DMA  ? dma_i[1]  : '0;
      SEL_BUF:   mux = HAS_DMA  ? rxbuf_i   : '0;
      default:   mux = '0;
    endcase
  end

  // two-stage local completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; v2_q <= 1'b0;
      d1_q <= '0;   d2_q <= '0;
    end else begin
      v1_q <= acc_i;
      d1_q <= hit_i ? mux : '0;
      v2_q <= v1_q;
      d2_q <= d1_q;
    end
  end

  assign ack_o   = v2_q | drv_ack_i;
  assign rdata_o = drv_ack_i ? drv_rdata_i : d2_q;
endmodule

// File: rtl/ata_host_regs.sv
module ata_host_regs
  import ahr_pkg::*;
#(
  parameter int unsigned CORE_VER     = 3,
  parameter logic [3:0]  REV          = 4'h1,
  parameter int unsigned DW           = 32,
  parameter int unsigned DRV_AW       = 7,
  parameter int unsigned CTRL_RST_BIT = 0,
  parameter int unsigned CTRL_EN_BIT  = 7,
  parameter int unsigned DEV_BIT      = 4,
  parameter logic [DRV_AW-1:0] DATA_OFF    = 'h00,
  parameter logic [DRV_AW-1:0] DEVHEAD_OFF = 'h18,
  parameter logic [7:0]  PIO_T1   = 8'd6,
  parameter logic [7:0]  PIO_T2   = 8'd28,
  parameter logic [7:0]  PIO_T4   = 8'd2,
  parameter logic [7:0]  PIO_TEOC = 8'd23,
  parameter logic [7:0]  DMA_TM   = 8'd4,
  parameter logic [7:0]  DMA_TD   = 8'd21,
  parameter logic [7:0]  DMA_TEOC = 8'd21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DRV_AW:0]   addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ack_o,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     rxbuf_i,
  input  logic              irq_i,
  output logic              irq_o,
  output logic              drv_rst_o,
  output logic              drv_req_o,
  output logic              drv_we_o,
  output logic [DRV_AW-1:0] drv_addr_o,
  output logic [DW-1:0]     drv_wdata_o,
  output logic              drv_dev_o,
  output logic [DW-1:0]     drv_timing_o,
  input  logic              drv_ack_i,
  input  logic [DW-1:0]     drv_rdata_i
);
  localparam int unsigned ADDR_W  = DRV_AW + 1;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAP_LSB = SEL_LSB + SEL_W;
  localparam logic [DW-1:0] CTRL_RST = DW'(1) << CTRL_RST_BIT;
  localparam logic [DW-1:0] PIO_RST  = DW'(pio_word(PIO_T1, PIO_T2, PIO_T4, PIO_TEOC));
  localparam logic [DW-1:0] DMA_RST  = DW'(dma_word(DMA_TM, DMA_TD, DMA_TEOC));

  logic               is_drv, ctrl_en, host_acc, fwd, local_acc, in_map, wr, hit;
  reg_sel_e           sel;
  logic [DW-1:0]      ctrl_q, pio_q, stat_word;
  logic               ist_q;
  logic [1:0][DW-1:0] fast_q, dma_q;

  assign is_drv    = addr_i[ADDR_W-1];
  assign ctrl_en   = ctrl_q[CTRL_EN_BIT];
  assign host_acc  = req_i && !is_drv;
  assign fwd       = req_i && is_drv && ctrl_en;
  assign local_acc = req_i && !fwd;
  assign in_map    = addr_i[DRV_AW-1:MAP_LSB] == '0;
  assign sel       = reg_sel_e'(addr_i[SEL_LSB +: SEL_W]);
  assign wr        = host_acc && we_i && in_map;
  assign hit       = host_acc && !we_i && in_map;
  assign stat_word = {4'(CORE_VER), REV, {(DW-9){1'b0}}, ist_q};

  ahr_regfile #(
    .CORE_VER(CORE_VER), .DW(DW), .CTRL_RST(CTRL_RST), .PIO_RST(PIO_RST), .DMA_RST(DMA_RST)
  ) i_regfile (
    .clk_i, .rst_ni, .wr_i(wr), .wsel_i(sel), .wdata_i, .irq_i,
    .ctrl_o(ctrl_q), .ist_o(ist_q), .pio_o(pio_q), .fast_o(fast_q), .dma_o(dma_q)
  );

  ahr_route #(
    .CORE_VER(CORE_VER), .DW(DW), .DRV_AW(DRV_AW), .DATA_OFF(DATA_OFF), .DEVHEAD_OFF(DEVHEAD_OFF)
  ) i_route (
    .clk_i, .rst_ni, .fwd_i(fwd), .we_i, .addr_i(addr_i[DRV_AW-1:0]),
    .dev_bit_i(wdata_i[DEV_BIT]), .pio_i(pio_q), .fast_i(fast_q),
    .timing_o(drv_timing_o), .dev_o(drv_dev_o)
  );

  ahr_resp #(.CORE_VER(CORE_VER), .DW(DW)) i_resp (
    .clk_i, .rst_ni, .acc_i(local_acc), .hit_i(hit), .sel_i(sel),
    .ctrl_i(ctrl_q), .stat_i(stat_word), .pio_i(pio_q), .fast_i(fast_q), .dma_i(dma_q),
    .rxbuf_i, .drv_ack_i, .drv_rdata_i, .ack_o, .rdata_o
  );

  assign drv_req_o   = fwd;
  assign drv_we_o    = we_i;
  assign drv_addr_o  = addr_i[DRV_AW-1:0];
  assign drv_wdata_o = wdata_i;
  assign drv_rst_o   = ctrl_q[CTRL_RST_BIT];
  assign irq_o       = ist_q;
endmodule

// File: rtl/ata_host_regs_chk.sv
module ata_host_regs_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0,
  input logic              ack_o,
  input logic              drv_req_o,
  input logic              drv_rst_o,
  input logic              irq_i,
  input logic              irq_o,
  input logic              ctrl_en
);
  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && addr_i == '0;

  AST_LOCAL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !addr_i[ADDR_W-1] |-> ##2 ack_o);  // R8
  AST_BLOCKED_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_req_o |-> ctrl_en);  // R5
  AST_HOST_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !addr_i[ADDR_W-1] |-> !drv_req_o);  // R6
  AST_RST_TAKES_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> drv_rst_o == $past(wbit0));  // R4
  AST_RST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(drv_rst_o));  // R4
  AST_IRQ_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o ##1 irq_o |-> $past(irq_i));  // R3
endmodule

bind ata_host_regs ata_host_regs_chk #(.ADDR_W(DRV_AW + 1)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wbit0(wdata_i[CTRL_RST_BIT]),
  .ack_o, .drv_req_o, .drv_rst_o, .irq_i, .irq_o, .ctrl_en
);

// File: tb/test_ata_host_regs.sv
module test_ata_host_regs;
  localparam logic [3:0]  REV = 4'h2;
  localparam logic [31:0] RXB = 32'hCAFE_F00D;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, req = 1'b0, we = 1'b0, irq = 1'b0, dack = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, drdata = '0;

  logic        ack3, irq3, rst3, dreq3, dwe3, dev3, ack1, irq1, rst1, dreq1, dwe1, dev1;
  logic [31:0] rd3, dwd3, tim3, rd1, dwd1, tim1;
  logic [6:0]  da3, da1;

  ata_host_regs #(.CORE_VER(3), .REV(REV)) i_ata_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack3), .rdata_o(rd3), .rxbuf_i(RXB), .irq_i(irq), .irq_o(irq3), .drv_rst_o(rst3),
    .drv_req_o(dreq3), .drv_we_o(dwe3), .drv_addr_o(da3), .drv_wdata_o(dwd3), .drv_dev_o(dev3),
    .drv_timing_o(tim3), .drv_ack_i(dack), .drv_rdata_i(drdata));

  ata_host_regs #(.CORE_VER(1), .REV(REV)) i_ata_host_regs_v1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack1), .rdata_o(rd1), .rxbuf_i(RXB), .irq_i(irq), .irq_o(irq1), .drv_rst_o(rst1),
    .drv_req_o(dreq1), .drv_we_o(dwe1), .drv_addr_o(da1), .drv_wdata_o(dwd1), .drv_dev_o(dev1),
    .drv_timing_o(tim1), .drv_ack_i(dack), .drv_rdata_i(drdata));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_ctrl, m_pctr;
  logic [31:0] m_pf [2];
  logic [31:0] m_dt [2];
  logic        m_ist, m_dev;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h1; m_ist = 1'b0;
    end else begin
      if (req && we && addr == 8'h00) m_ctrl = wdata;
      m_ist = irq | (m_ist & !(req && we && addr == 8'h04 && !wdata[0]));
    end
  end

  // per-clock comparison of the state-following outputs
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4", {31'b0, rst3}, {31'b0, m_ctrl[0]});
    chk("R4", {31'b0, rst1}, {31'b0, m_ctrl[0]});
    chk("R3", {31'b0, irq3}, {31'b0, m_ist});
    chk("R3", {31'b0, irq1}, {31'b0, m_ist});
  end

  function automatic logic [31:0] exp_rd(int ver, logic [7:0] a);
    if (a[7] || a[6:5] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_ctrl;
      3'd1: return {4'(ver), REV, 23'b0, m_ist};
      3'd2: return m_pctr;
      3'd3: return (ver >= 2) ? m_pf[0] : 32'h0;
      3'd4: return (ver >= 2) ? m_pf[1] : 32'h0;
      3'd5: return (ver >= 3) ? m_dt[0] : 32'h0;
      3'd6: return (ver >= 3) ? m_dt[1] : 32'h0;
      default: return (ver >= 3) ? RXB : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_tim(int ver, logic [7:0] a);
    return (ver >= 2 && a[6:0] == 7'h00) ? m_pf[m_dev] : m_pctr;
  endfunction

  task automatic acc(bit w, logic [7:0] a, logic [31:0] d, string tag);
    logic [31:0] e3, e1, et3, et1, pat;
    logic efwd, edev, f3, f1, fwe, fd;
    logic [6:0] fa;
    logic [31:0] ft3, ft1, fwd_d;
    int cyc;
    e3 = exp_rd(3, a); e1 = exp_rd(1, a);
    efwd = a[7] && m_ctrl[7];
    et3 = exp_tim(3, a); et1 = exp_tim(1, a); edev = m_dev;
    pat = {16'hD00D, 9'b0, a[6:0]};
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    f3 = dreq3; f1 = dreq1; fa = da3; fwe = dwe3; fwd_d = dwd3; ft3 = tim3; ft1 = tim1; fd = dev3;
    @(negedge clk);
    req = 1'b0;
    chk(a[7] ? "R5" : "R6", {31'b0, f3}, {31'b0, efwd});
    chk(a[7] ? "R5" : "R6", {31'b0, f1}, {31'b0, efwd});
    if (efwd) begin
      chk("R6", {25'b0, fa}, {25'b0, a[6:0]});
      chk("R6", {31'b0, fwe}, {31'b0, w});
      if (w) chk("R6", fwd_d, d);
      chk("R7", ft3, et3);
      chk("R7", {31'b0, fd}, {31'b0, edev});
      chk("R10", ft1, et1);
      dack = 1'b1; drdata = pat;
      #1;
      chk("R11", {31'b0, ack3}, 32'h1);
      if (!w) chk("R11", rd3, pat);
      @(negedge clk);
      dack = 1'b0;
    end else begin
      cyc = 1;
      #1;
      while (!ack3 && cyc < 8) begin
        @(negedge clk); #1; cyc++;
      end
      chk("R8", cyc, 2);
      if (!w) begin
        chk(tag, rd3, a[7] ? 32'h0 : e3);
        chk("R10", rd1, a[7] ? 32'h0 : e1);
      end
    end
    if (w && !a[7] && a[6:5] == 2'b00) begin
      case (a[4:2])
        3'd2: m_pctr = d;
        3'd3: m_pf[0] = d;
        3'd4: m_pf[1] = d;
        3'd5: m_dt[0] = d;
        3'd6: m_dt[1] = d;
        default: ;
      endcase
    end
    if (w && efwd && a[6:0] == 7'h18) m_dev = d[4];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pctr = 32'h17021C06; m_pf[0] = 32'h17021C06; m_pf[1] = 32'h17021C06;
    m_dt[0] = 32'h15001504; m_dt[1] = 32'h15001504; m_dev = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, rst3}, 32'h1);
    rst_n = 1'b1;
    // reset values
    acc(0, 8'h00, 0, "R1");
    acc(0, 8'h04, 0, "R2");
    acc(0, 8'h08, 0, "R1");
    acc(0, 8'h0C, 0, "R1");
    acc(0, 8'h10, 0, "R1");
    acc(0, 8'h14, 0, "R1");
    acc(0, 8'h18, 0, "R1");
    // drive access while disabled
    acc(0, 8'h84, 0, "R5");
    // enable, reset toggles
    acc(1, 8'h00, 32'h81, "R4");
    acc(1, 8'h00, 32'h80, "R4");
    acc(0, 8'h00, 0, "R4");
    // status fields read-only
    acc(1, 8'h04, 32'hFFFF_FFFF, "R2");
    acc(0, 8'h04, 0, "R2");
    // interrupt set, keep on write-1, clear on write-0
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    acc(0, 8'h04, 0, "R3");
    acc(1, 8'h04, 32'h1, "R3");
    acc(0, 8'h04, 0, "R3");
    acc(1, 8'h04, 32'h0, "R3");
    acc(0, 8'h04, 0, "R3");
    // set wins over a clearing write
    irq = 1'b1;
    acc(1, 8'h04, 32'h0, "R3");
    irq = 1'b0;
    acc(0, 8'h04, 0, "R3");
    acc(1, 8'h04, 32'h0, "R3");
    // timing words
    acc(1, 8'h08, 32'h1122_3344, "R9");
    acc(1, 8'h0C, 32'h5566_7788, "R9");
    acc(1, 8'h10, 32'h99AA_BBCC, "R9");
    acc(1, 8'h14, 32'h0102_0304, "R9");
    acc(1, 8'h18, 32'h0506_0708, "R9");
    acc(0, 8'h08, 0, "R9");
    acc(0, 8'h0C, 0, "R10");
    acc(0, 8'h10, 0, "R10");
    acc(0, 8'h14, 0, "R10");
    acc(0, 8'h18, 0, "R10");
    // receive buffer read-only, unmapped offsets
    acc(1, 8'h1C, 32'h0BAD_0BAD, "R9");
    acc(0, 8'h1C, 0, "R9");
    acc(1, 8'h20, 32'hFFFF_FFFF, "R9");
    acc(0, 8'h20, 0, "R9");
    acc(0, 8'h7C, 0, "R9");
    acc(0, 8'h00, 0, "R9");
    // forwarded accesses and timing selection
    acc(0, 8'h84, 0, "R6");
    acc(0, 8'h80, 0, "R7");
    acc(1, 8'h98, 32'h10, "R7");
    acc(0, 8'h80, 0, "R7");
    acc(1, 8'h80, 32'h1234_5678, "R7");
    acc(0, 8'h9C, 0, "R11");
    // blocked write leaves device selection alone
    acc(1, 8'h00, 32'h00, "R5");
    acc(1, 8'h98, 32'h00, "R5");
    acc(0, 8'h80, 0, "R5");
    acc(1, 8'h00, 32'h80, "R5");
    acc(0, 8'h80, 0, "R5");
    acc(1, 8'h98, 32'h00, "R7");
    acc(0, 8'h80, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule